// File: doc/BRIEF.md
# Platform Interrupt Router

This block gathers interrupt requests from a set of external sources and presents them to a small number of processor contexts. Every source passes through a gateway that turns a level-high or rising-edge input into a single pending request. A request then stays blocked at that gateway until software signals completion. Each context has its own enable mask and its own priority threshold, and it drives one interrupt line of its own.

Software reaches the block through a word-wide register port with a sparse, fixed address map. A handler reads the claim register of its context and gets back the best eligible source. That read also clears the source's pending bit. When the handler has finished, it writes the same ID back to the claim register. Source 0 is reserved: it never pends and always reads as zero. The default configuration has sources 1 to 31, 3-bit priorities and two contexts. Sources 16 to 31 are rising-edge and the rest are level-high, as set by a parameter mask.

The port takes one access per cycle. Read data comes back registered, one cycle after the read strobe. The byte address is 24 bits wide and must be word aligned.

Top module: `irq_router`

## Requirements
- R1: Source n has a priority register at byte address 4·n, holding a 3-bit value. The register for ID 0 reads 0 and ignores writes.
- R2: Address 0x1000 is a read-only word of pending bits, where bit n is source n. Writing it changes nothing.
- R3: Context c has an enable word at 0x2000 + 0x80·c, where bit n enables source n. Bit 0 always reads 0.
- R4: A source is eligible for a context only when it is pending, enabled there and its priority is strictly above that context's threshold, which sits at 0x200000 + 0x1000·c. Two cycles after eligibility changes, the irq_out bit of that context is high exactly when an eligible source exists. This means a threshold of 7 masks everything and a priority of 0 never interrupts.
- R5: A read of the claim register at 0x200004 + 0x1000·c returns the eligible source with the highest priority, with ties going to the lowest ID. The read clears that source's pending bit. It returns 0, with no side effect, when nothing is eligible.
- R6: Once a source is claimed, its gateway raises no new request until its ID is written to a claim register. After that write, a level source whose input is still high pends again.
- R7: An edge source pends on a rising edge and stays pending after its input falls. An edge that arrives while the source is awaiting completion is dropped.
- R8: A completion write is ignored if its ID is 0, is not below 32, or is not enabled in the writing context.
- R9: A source that is disabled for a context still becomes pending, but it does not raise that context's line and cannot be claimed there.
- R10: Unmapped or unaligned addresses, and contexts beyond the last one, read as 0 and ignore writes.
- R11: After reset all registers are zero and irq_out and reg_rdata are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 31 | Request inputs for sources 1 to 31 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 24 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| irq_out | output | 2 | Interrupt line per context |

## Verification
Two events can land on the same clock edge: a claim that clears a source, and a new request arriving at that source's gateway. The bench provokes this by holding level inputs high through a claim and by pulsing an edge input while its source awaits completion. It judges the outcome from the pending word at 0x1000, which must stay clear until a valid completion is written. A second overlap is completion writes to the claim register that are ignored while the source inputs are still asserted. The pending word shows whether any of those writes wrongly unblocked a gateway.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_ENAB,
    RG_THR,
    RG_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_in,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic busy
);
  logic req;

  generate
    if (EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_in;
      end
      assign req = src_in & ~prev_q;
    end else begin : g_level
      assign req = src_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (take) begin
        pend <= 1'b0;
        busy <= 1'b1;
      end else begin
        if (req && !pend && !busy) pend <= 1'b1;
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        en,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      thr,
  output logic [ID_W-1:0]        win_id,
  output logic                   any
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare keeps the lowest ID on a tie.
  always_comb begin
    best   = '0;
    win_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && en[i] &&
          prio_flat[i*PRIO_W +: PRIO_W] > thr &&
          prio_flat[i*PRIO_W +: PRIO_W] > best) begin
        best   = prio_flat[i*PRIO_W +: PRIO_W];
        win_id = ID_W'(i);
      end
    end
    any = (win_id != '0);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          NSRC      = 32,
  parameter int          NCTX      = 2,
  parameter int          PRIO_W    = 3,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:1]   irq_src,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCTX-1:0]   irq_out
);
  localparam int ID_W  = $clog2(NSRC);
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  // Configuration storage, kept flat so the arbiters slice it directly.
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NCTX*PRIO_W-1:0] thr_flat;
  logic [NCTX*NSRC-1:0]   en_flat;

  logic [NSRC-1:0] pend_vec, busy_vec, take_vec, done_vec;
  logic [ID_W-1:0] win_ids [NCTX];
  logic [NCTX-1:0] any_vec;

  // Address decode
  reg_kind_e       sel_kind;
  logic [ID_W-1:0] sel_src;
  logic [CTX_W-1:0] sel_ctx;

  always_comb begin
    sel_kind = RG_NONE;
    sel_src  = '0;
    sel_ctx  = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr[23:12] == 12'h000) begin
        if (reg_addr[11:2] != '0 && int'(reg_addr[11:2]) < NSRC) begin
          sel_kind = RG_PRIO;
          sel_src  = reg_addr[ID_W+1:2];
        end
      end else if (reg_addr[23:12] == 12'h001) begin
        if (reg_addr[11:2] == '0) sel_kind = RG_PEND;
      end else if (reg_addr[23:12] == 12'h002) begin
        if (reg_addr[6:2] == '0 && int'(reg_addr[11:7]) < NCTX) begin
          sel_kind = RG_ENAB;
          sel_ctx  = CTX_W'(reg_addr[11:7]);
        end
      end else if (reg_addr[23:21] == 3'b001) begin
        if (int'(reg_addr[20:12]) < NCTX) begin
          sel_ctx = CTX_W'(reg_addr[20:12]);
          if (reg_addr[11:0] == 12'h000)      sel_kind = RG_THR;
          else if (reg_addr[11:0] == 12'h004) sel_kind = RG_CLAIM;
        end
      end
    end
  end

  // Configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_flat <= '0;
      thr_flat  <= '0;
      en_flat   <= '0;
    end else if (reg_we) begin
      case (sel_kind)
        RG_PRIO: prio_flat[sel_src*PRIO_W +: PRIO_W] <= reg_wdata[PRIO_W-1:0];
        RG_THR:  thr_flat[sel_ctx*PRIO_W +: PRIO_W]  <= reg_wdata[PRIO_W-1:0];
        RG_ENAB: en_flat[sel_ctx*NSRC +: NSRC]       <= reg_wdata[NSRC-1:0] & ~NSRC'(1);
        default: ;
      endcase
    end
  end

  // Claim and completion strobes toward the gateways
  always_comb begin
    take_vec = '0;
    done_vec = '0;
    if (reg_re && sel_kind == RG_CLAIM && win_ids[sel_ctx] != '0)
      take_vec[win_ids[sel_ctx]] = 1'b1;
    if (reg_we && sel_kind == RG_CLAIM && reg_wdata != '0 &&
        reg_wdata < DATA_W'(NSRC) &&
        en_flat[sel_ctx*NSRC + int'(reg_wdata[ID_W-1:0])])
      done_vec[reg_wdata[ID_W-1:0]] = 1'b1;
  end

  // Gateways, one per implemented source
  assign pend_vec[0] = 1'b0;
  assign busy_vec[0] = 1'b0;

  generate
    for (genvar s = 1; s < NSRC; s++) begin : g_gw
      irq_gateway #(.EDGE(EDGE_MASK[s])) u_gw (
        .clk    (clk),
        .rst    (rst),
        .src_in (irq_src[s]),
        .take   (take_vec[s]),
        .done   (done_vec[s]),
        .pend   (pend_vec[s]),
        .busy   (busy_vec[s])
      );
    end
  endgenerate

  // Arbiters, one per context
  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_arb
      irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .pend      (pend_vec),
        .en        (en_flat[c*NSRC +: NSRC]),
        .prio_flat (prio_flat),
        .thr       (thr_flat[c*PRIO_W +: PRIO_W]),
        .win_id    (win_ids[c]),
        .any       (any_vec[c])
      );
    end
  endgenerate

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= '0;
      reg_rdata <= '0;
    end else begin
      irq_out <= any_vec;
      if (reg_re) begin
        case (sel_kind)
          RG_PRIO:  reg_rdata <= DATA_W'(prio_flat[sel_src*PRIO_W +: PRIO_W]);
          RG_PEND:  reg_rdata <= DATA_W'(pend_vec);
          RG_ENAB:  reg_rdata <= DATA_W'(en_flat[sel_ctx*NSRC +: NSRC]);
          RG_THR:   reg_rdata <= DATA_W'(thr_flat[sel_ctx*PRIO_W +: PRIO_W]);
          RG_CLAIM: reg_rdata <= DATA_W'(win_ids[sel_ctx]);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCTX-1:0]        irq_out,
  input logic [31:0]            reg_rdata,
  input logic [NSRC-1:0]        pend,
  input logic [NSRC-1:0]        busy,
  input logic [NSRC-1:0]        take,
  input logic [NCTX*PRIO_W-1:0] thr
);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && reg_rdata == '0));

  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & busy) == '0);

  // R5
  claim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));

  // R5
  claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|take) |=> ((pend & $past(take)) == '0));

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      // R4
      thr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (thr[c*PRIO_W +: PRIO_W] == '1 && $past(thr[c*PRIO_W +: PRIO_W] == '1))
          |-> !irq_out[c]);
    end
  endgenerate
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .reg_rdata (reg_rdata),
  .pend      (pend_vec),
  .busy      (busy_vec),
  .take      (take_vec),
  .thr       (thr_flat)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:1] src = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [23:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  logic mon_v = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .irq_src(src), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [23:0] a_prio(int n); return 24'(4*n); endfunction
  function automatic logic [23:0] a_en(int c);   return 24'(32'h2000 + 32'h80*c); endfunction
  function automatic logic [23:0] a_thr(int c);  return 24'(32'h200000 + 32'h1000*c); endfunction
  function automatic logic [23:0] a_clm(int c);  return 24'(32'h200004 + 32'h1000*c); endfunction
  localparam logic [23:0] A_PEND = 24'h001000;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Driver: issues a read and queues the expected result.
  task automatic rd(logic [23:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  // Monitor: compares each read result one cycle after its strobe.
  always @(posedge clk) mon_v <= reg_re;
  always @(negedge clk) begin
    if (mon_v) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    check("R11 rdata in reset", reg_rdata, 32'h0);
    check("R11 irq in reset", {30'b0, irq_out}, 32'h0);
    rst = 1'b0;
    idle(2);
    rd(a_prio(5), 32'h0, "R11 prio reset");
    rd(a_en(0), 32'h0, "R11 enable reset");

    // R1 priorities
    wr(a_prio(0), 32'h5);
    wr(a_prio(3), 32'h6);
    wr(a_prio(31), 32'h7);
    rd(a_prio(0), 32'h0, "R1 id0 prio");
    rd(a_prio(3), 32'h6, "R1 prio3");
    rd(a_prio(31), 32'h7, "R1 prio31");

    // R3 enables, R10 unmapped
    wr(a_en(0), 32'hFFFF_FFFF);
    wr(a_en(1), 32'h0);
    wr(24'h002100, 32'h0);
    wr(24'h001800, 32'hFFFF_FFFF);
    rd(a_en(0), 32'hFFFF_FFFE, "R3 ctx0 enable bit0 clear");
    rd(a_en(1), 32'h0, "R3 ctx1 enable");
    rd(24'h001800, 32'h0, "R10 unmapped read");
    rd(a_thr(0) + 24'h8, 32'h0, "R10 page offset 8");
    rd(24'h000006, 32'h0, "R10 unaligned");

    // R9 / R2 / R4: level source 3, priority 6
    src[3] = 1'b1;
    idle(3);
    rd(A_PEND, 32'h8, "R2 pending bit3");
    check("R4 ctx0 irq", {30'b0, irq_out}, 32'h1);
    rd(a_clm(1), 32'h0, "R9 claim disabled ctx");
    wr(A_PEND, 32'h0);
    rd(A_PEND, 32'h8, "R2 pending read-only");

    // R4 thresholds
    wr(a_thr(0), 32'h7);
    idle(3);
    check("R4 threshold 7 masks", {30'b0, irq_out}, 32'h0);
    wr(a_thr(0), 32'h6);
    idle(3);
    check("R4 prio equal threshold", {30'b0, irq_out}, 32'h0);
    wr(a_thr(0), 32'h5);
    idle(3);
    check("R4 prio above threshold", {30'b0, irq_out}, 32'h1);
    rd(a_thr(0), 32'h5, "R4 threshold readback");
    wr(a_thr(0), 32'h0);

    // R5 arbitration, R6 blocking
    wr(a_prio(2), 32'h3);
    wr(a_prio(4), 32'h6);
    src[2] = 1'b1; src[4] = 1'b1;
    idle(3);
    rd(A_PEND, 32'h1C, "R5 three pending");
    rd(a_clm(0), 32'd3, "R5 tie lowest id");
    rd(a_clm(0), 32'd4, "R5 second winner");
    rd(a_clm(0), 32'd2, "R5 lower priority last");
    rd(a_clm(0), 32'd0, "R5 empty claim");
    idle(3);
    rd(A_PEND, 32'h0, "R6 blocked while high");
    check("R5 irq drops after claims", {30'b0, irq_out}, 32'h0);

    // R8 ignored completions
    wr(a_clm(0), 32'd0);
    wr(a_clm(0), 32'd40);
    wr(a_clm(1), 32'd3);
    idle(3);
    rd(A_PEND, 32'h0, "R8 bad completions ignored");

    // R6 completion re-arms level sources
    wr(a_clm(0), 32'd3);
    idle(3);
    rd(A_PEND, 32'h8, "R6 level re-pends");
    src[2] = 1'b0; src[4] = 1'b0;
    wr(a_clm(0), 32'd2);
    wr(a_clm(0), 32'd4);
    idle(3);
    rd(A_PEND, 32'h8, "R6 low inputs stay clear");
    rd(a_clm(0), 32'd3, "R6 reclaim");
    src[3] = 1'b0;
    wr(a_clm(0), 32'd3);
    idle(3);
    rd(A_PEND, 32'h0, "R6 all idle");

    // R7 edge source 20 on ctx1
    wr(a_prio(20), 32'h2);
    wr(a_en(1), 32'h0010_0000);
    wr(a_thr(1), 32'h1);
    src[20] = 1'b1;
    idle(1);
    src[20] = 1'b0;
    idle(3);
    rd(A_PEND, 32'h0010_0000, "R7 edge latched");
    check("R7 both lines", {30'b0, irq_out}, 32'h3);
    rd(a_clm(1), 32'd20, "R7 claim edge source");
    idle(3);
    check("R7 lines drop", {30'b0, irq_out}, 32'h0);
    src[20] = 1'b1;
    idle(1);
    src[20] = 1'b0;
    idle(3);
    rd(A_PEND, 32'h0, "R7 edge while busy dropped");
    wr(a_clm(1), 32'd20);
    idle(3);
    rd(A_PEND, 32'h0, "R7 no edge no pend");
    src[20] = 1'b1;
    idle(1);
    src[20] = 1'b0;
    idle(3);
    rd(A_PEND, 32'h0010_0000, "R7 new edge pends");

    idle(4);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule